// File: doc/BRIEF.md
# Chained Vector Arithmetic Unit

This block is a small vector execution engine with its own register file of `NREG` vectors, each `MAXVL` elements of `W` bits. One instruction at a time enters through an issue port that carries an opcode, a destination, two sources and a scalar operand. Arithmetic instructions (integer add and multiply, vector-vector or vector-scalar) stream through a two-stage pipeline at one element per clock. A length register limits how many elements an instruction touches, and a mask register decides which of those elements are actually written.

A second vector instruction may be accepted while the first is still streaming. It then starts exactly two cycles behind the first. If it reads the first one's destination, each element is forwarded from the first pipeline's output stage in the cycle it is produced, so the pair runs as one convoy. Once a pair has formed, further vector instructions wait until the unit is idle. Length and mask updates are executed at once and are copied into each instruction when it is accepted. A combinational read port exposes any element for inspection.

Top module: `vxu_chain_unit`

## Requirements
- R1: After reset every element is zero, the length is MAXVL, all mask bits are one, `busy` is low and `iss_ready` is high. `iss_ready` is high in every cycle in which `busy` is low.
- R2: Opcode 0 (vector add) sets element e of vd to vs1[e] + vs2[e], modulo 2^W.
- R3: Opcode 1 (vector-scalar add) sets element e of vd to vs1[e] + iss_scalar, with the same scalar applied to every element.
- R4: Opcode 2 (vector multiply) and opcode 3 (vector-scalar multiply) write the low W bits of vs1[e] * vs2[e] and of vs1[e] * iss_scalar respectively.
- R5: Opcode 4 loads the length from iss_scalar. Elements at an index equal to or above the length of an instruction are left unchanged.
- R6: Opcode 5 loads the mask from iss_scalar, with bit e controlling element e. An element whose mask bit is 0 keeps its previous destination value.
- R7: An arithmetic instruction issued with length 0 holds `busy` high for exactly one cycle and writes nothing.
- R8: A length request above MAXVL is clamped to MAXVL.
- R9: A lone arithmetic instruction of n >= 1 elements is accepted on a clock edge, and `busy` falls n+2 edges after that edge. Its results are readable from then on.
- R10: A second arithmetic instruction accepted one cycle after the first forms a chained pair. It reads each element of the first instruction's result in the cycle that element is produced. `busy` falls n+3 edges after the second instruction's acceptance edge, and the register contents equal in-order execution of both instructions.
- R11: Once a pair has formed, `iss_ready` stays low until `busy` falls.
- R12: Opcodes 4 and 5 are taken on any cycle with `iss_valid` high, whatever the state of `iss_ready`. Arithmetic opcodes are taken only when `iss_valid` and `iss_ready` are both high. An instruction already accepted keeps the length and mask it was accepted with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 3 | Opcode (0..5, see requirements) |
| iss_vd | input | log2(NREG) | Destination vector register |
| iss_vs1 | input | log2(NREG) | First source vector register |
| iss_vs2 | input | log2(NREG) | Second source vector register |
| iss_scalar | input | W | Scalar operand, new length or new mask |
| iss_ready | output | 1 | An arithmetic instruction can be accepted |
| busy | output | 1 | Any instruction is still streaming or in the pipeline |
| dbg_reg | input | log2(NREG) | Inspection port register select |
| dbg_idx | input | log2(MAXVL) | Inspection port element select |
| dbg_data | output | W | Stored element value, combinational |

## Verification
A lone instruction of n elements is due n+2 edges after the edge that accepts it. A chained pair is due n+3 edges after the consumer's acceptance edge, and a zero-length instruction one edge after acceptance. Length and mask changes apply to the next accepted instruction. The bench counts rising edges from the acceptance edge and samples `busy` at each falling edge. A count is therefore compared only in the half cycle right after the last register write. Register contents are read through the inspection port only after `busy` has fallen, and are compared with an in-order model kept in the bench.

// File: rtl/vxu_pkg.sv
package vxu_pkg;

   typedef enum logic [2:0] {
      OP_ADDVV   = 3'd0,
      OP_ADDVS   = 3'd1,
      OP_MULVV   = 3'd2,
      OP_MULVS   = 3'd3,
      OP_SETLEN  = 3'd4,
      OP_SETMASK = 3'd5
   } vop_e;

   // Arithmetic opcodes have the top bit clear.
   function automatic logic op_is_arith(input logic [2:0] op);
      return !op[2];
   endfunction

   function automatic logic op_is_mul(input logic [2:0] op);
      return op[1];
   endfunction

   function automatic logic op_uses_scalar(input logic [2:0] op);
      return op[0];
   endfunction

endpackage

// File: rtl/vxu_vrf.sv
// Vector register file: two write ports fed by the pipelines, NRD operand
// read ports with bypass from the write ports, and one plain inspection port.
module vxu_vrf #(
   parameter  int W     = 64,
   parameter  int MAXVL = 64,
   parameter  int NREG  = 4,
   parameter  int NWR   = 2,
   parameter  int NRD   = 4,
   localparam int RW    = (NREG  > 1) ? $clog2(NREG)  : 1,
   localparam int IW    = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NWR-1:0]           we,
   input  logic [NWR-1:0][RW-1:0]   wreg,
   input  logic [NWR-1:0][IW-1:0]   widx,
   input  logic [NWR-1:0][W-1:0]    wdata,
   input  logic [NRD-1:0][RW-1:0]   rreg,
   input  logic [NRD-1:0][IW-1:0]   ridx,
   output logic [NRD-1:0][W-1:0]    rdata,
   input  logic [RW-1:0]            dbg_reg,
   input  logic [IW-1:0]            dbg_idx,
   output logic [W-1:0]             dbg_data
);

   logic [W-1:0] mem [NREG][MAXVL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++)
            for (int e = 0; e < MAXVL; e++)
               mem[r][e] <= '0;
      end else begin
         for (int p = 0; p < NWR; p++)
            if (we[p]) mem[wreg[p]][widx[p]] <= wdata[p];
      end
   end

   // A value being written this cycle is forwarded to a reader of the same
   // element, which is what lets a chained consumer run two cycles behind.
   always_comb begin
      for (int p = 0; p < NRD; p++) begin
         rdata[p] = mem[rreg[p]][ridx[p]];
         for (int q = 0; q < NWR; q++)
            if (we[q] && wreg[q] == rreg[p] && widx[q] == ridx[p])
               rdata[p] = wdata[q];
      end
   end

   assign dbg_data = mem[dbg_reg][dbg_idx];

endmodule

// File: rtl/vxu_seq.sv
// Element sequencer for one instruction slot: captures the instruction,
// length and mask at acceptance and walks the element index.
module vxu_seq #(
   parameter  int W     = 64,
   parameter  int MAXVL = 64,
   parameter  int NREG  = 4,
   localparam int RW    = (NREG  > 1) ? $clog2(NREG)  : 1,
   localparam int IW    = (MAXVL > 1) ? $clog2(MAXVL) : 1,
   localparam int LW    = $clog2(MAXVL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [2:0]       st_op,
   input  logic [RW-1:0]    st_vd,
   input  logic [RW-1:0]    st_vs1,
   input  logic [RW-1:0]    st_vs2,
   input  logic [W-1:0]     st_scalar,
   input  logic [LW-1:0]    st_len,
   input  logic [MAXVL-1:0] st_mask,
   input  logic             go,
   output logic             active,
   output logic             elem_issue,
   output logic             elem_wr,
   output logic [IW-1:0]    idx,
   output logic [RW-1:0]    vd,
   output logic [RW-1:0]    vs1,
   output logic [RW-1:0]    vs2,
   output logic             is_mul,
   output logic             use_scalar,
   output logic [W-1:0]     scalar
);
   import vxu_pkg::*;

   logic             active_q;
   logic [IW-1:0]    idx_q;
   logic [2:0]       op_q;
   logic [LW-1:0]    len_q;
   logic [MAXVL-1:0] mask_q;
   logic             last;

   assign last = (len_q == '0) || (LW'(idx_q) == len_q - LW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         op_q     <= '0;
         len_q    <= '0;
         mask_q   <= '0;
         vd       <= '0;
         vs1      <= '0;
         vs2      <= '0;
         scalar   <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         idx_q    <= '0;
         op_q     <= st_op;
         len_q    <= st_len;
         mask_q   <= st_mask;
         vd       <= st_vd;
         vs1      <= st_vs1;
         vs2      <= st_vs2;
         scalar   <= st_scalar;
      end else if (active_q && go) begin
         if (last) active_q <= 1'b0;
         else      idx_q    <= idx_q + IW'(1);
      end
   end

   assign active     = active_q;
   assign idx        = idx_q;
   assign elem_issue = active_q && go && (len_q != '0);
   assign elem_wr    = elem_issue && mask_q[idx_q];
   assign is_mul     = op_is_mul(op_q);
   assign use_scalar = op_uses_scalar(op_q);

endmodule

// File: rtl/vxu_pipe.sv
// Two-stage arithmetic pipeline: operand register, then result register
// that drives a register-file write port.
module vxu_pipe #(
   parameter  int W     = 64,
   parameter  int MAXVL = 64,
   parameter  int NREG  = 4,
   localparam int RW    = (NREG  > 1) ? $clog2(NREG)  : 1,
   localparam int IW    = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_occ,
   input  logic          in_wr,
   input  logic          in_mul,
   input  logic [W-1:0]  in_a,
   input  logic [W-1:0]  in_b,
   input  logic [RW-1:0] in_vd,
   input  logic [IW-1:0] in_idx,
   output logic          occupied,
   output logic          s2_occ,
   output logic [IW-1:0] s2_idx,
   output logic          wr_en,
   output logic [RW-1:0] wr_vd,
   output logic [W-1:0]  wr_data
);

   logic          s1_occ, s1_wr, s1_mul, s2_wr;
   logic [W-1:0]  s1_a, s1_b, s2_res;
   logic [RW-1:0] s1_vd;
   logic [IW-1:0] s1_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_occ <= 1'b0;
         s1_wr  <= 1'b0;
         s2_occ <= 1'b0;
         s2_wr  <= 1'b0;
      end else begin
         s1_occ <= in_occ;
         s1_wr  <= in_wr;
         s2_occ <= s1_occ;
         s2_wr  <= s1_wr;
      end
   end

   always_ff @(posedge clk) begin
      s1_mul <= in_mul;
      s1_a   <= in_a;
      s1_b   <= in_b;
      s1_vd  <= in_vd;
      s1_idx <= in_idx;
      s2_res <= s1_mul ? s1_a * s1_b : s1_a + s1_b;
      wr_vd  <= s1_vd;
      s2_idx <= s1_idx;
   end

   assign occupied = s1_occ || s2_occ;
   assign wr_en    = s2_occ && s2_wr;
   assign wr_data  = s2_res;

endmodule

// File: rtl/vxu_chain_unit.sv
module vxu_chain_unit #(
   parameter  int W     = 64,
   parameter  int MAXVL = 64,
   parameter  int NREG  = 4,
   localparam int RW    = (NREG  > 1) ? $clog2(NREG)  : 1,
   localparam int IW    = (MAXVL > 1) ? $clog2(MAXVL) : 1,
   localparam int LW    = $clog2(MAXVL + 1),
   localparam int NSLOT = 2,
   localparam int LAG   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          iss_valid,
   input  logic [2:0]    iss_op,
   input  logic [RW-1:0] iss_vd,
   input  logic [RW-1:0] iss_vs1,
   input  logic [RW-1:0] iss_vs2,
   input  logic [W-1:0]  iss_scalar,
   output logic          iss_ready,
   output logic          busy,
   input  logic [RW-1:0] dbg_reg,
   input  logic [IW-1:0] dbg_idx,
   output logic [W-1:0]  dbg_data
);
   import vxu_pkg::*;

   if (MAXVL > W) begin : g_bad_mask
      $error("MAXVL must not exceed W: the mask is loaded from the scalar");
   end
   if ((MAXVL & (MAXVL - 1)) != 0 || MAXVL < 2) begin : g_bad_len
      $error("MAXVL must be a power of two of at least 2");
   end
   if ((NREG & (NREG - 1)) != 0 || NREG < 2) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end

   logic [LW-1:0]    len_q;
   logic [MAXVL-1:0] mask_q;
   logic             paired_q;
   logic [1:0]       elapsed_q;

   logic [NSLOT-1:0]         s_start, s_go, s_act, s_iss, s_wr, s_mul, s_usc;
   logic [NSLOT-1:0][IW-1:0] s_idx;
   logic [NSLOT-1:0][RW-1:0] s_vd, s_vs1, s_vs2;
   logic [NSLOT-1:0][W-1:0]  s_sc, p_b;
   logic [NSLOT-1:0]         p_occ, p_s2occ, p_we;
   logic [NSLOT-1:0][IW-1:0] p_s2idx;
   logic [NSLOT-1:0][RW-1:0] p_vd;
   logic [NSLOT-1:0][W-1:0]  p_wd;

   logic [2*NSLOT-1:0][RW-1:0] rreg;
   logic [2*NSLOT-1:0][IW-1:0] ridx;
   logic [2*NSLOT-1:0][W-1:0]  rdata;

   logic accept_arith, cfg_len, cfg_mask;

   assign busy         = |s_act || |p_occ;
   assign iss_ready    = !s_act[1] && (!busy || (s_act[0] && !paired_q));
   assign accept_arith = iss_valid && iss_ready && op_is_arith(iss_op);
   assign cfg_len      = iss_valid && (iss_op == OP_SETLEN);
   assign cfg_mask     = iss_valid && (iss_op == OP_SETMASK);
   assign s_start[0]   = accept_arith && !busy;
   assign s_start[1]   = accept_arith && busy;
   assign s_go[0]      = 1'b1;
   assign s_go[1]      = (elapsed_q == 2'(LAG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q     <= LW'(MAXVL);
         mask_q    <= '1;
         paired_q  <= 1'b0;
         elapsed_q <= '0;
      end else begin
         if (cfg_len)
            len_q <= (iss_scalar > W'(MAXVL)) ? LW'(MAXVL) : iss_scalar[LW-1:0];
         if (cfg_mask)
            mask_q <= iss_scalar[MAXVL-1:0];
         if (s_start[1])  paired_q <= 1'b1;
         else if (!busy)  paired_q <= 1'b0;
         if (s_start[0])                    elapsed_q <= '0;
         else if (elapsed_q != 2'(LAG))     elapsed_q <= elapsed_q + 2'd1;
      end
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      vxu_seq #(.W(W), .MAXVL(MAXVL), .NREG(NREG)) u_seq (
         .clk        (clk),
         .rst_n      (rst_n),
         .start      (s_start[s]),
         .st_op      (iss_op),
         .st_vd      (iss_vd),
         .st_vs1     (iss_vs1),
         .st_vs2     (iss_vs2),
         .st_scalar  (iss_scalar),
         .st_len     (len_q),
         .st_mask    (mask_q),
         .go         (s_go[s]),
         .active     (s_act[s]),
         .elem_issue (s_iss[s]),
         .elem_wr    (s_wr[s]),
         .idx        (s_idx[s]),
         .vd         (s_vd[s]),
         .vs1        (s_vs1[s]),
         .vs2        (s_vs2[s]),
         .is_mul     (s_mul[s]),
         .use_scalar (s_usc[s]),
         .scalar     (s_sc[s])
      );

      assign rreg[2*s]     = s_vs1[s];
      assign rreg[2*s+1]   = s_vs2[s];
      assign ridx[2*s]     = s_idx[s];
      assign ridx[2*s+1]   = s_idx[s];
      assign p_b[s]        = s_usc[s] ? s_sc[s] : rdata[2*s+1];

      vxu_pipe #(.W(W), .MAXVL(MAXVL), .NREG(NREG)) u_pipe (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_occ   (s_iss[s]),
         .in_wr    (s_wr[s]),
         .in_mul   (s_mul[s]),
         .in_a     (rdata[2*s]),
         .in_b     (p_b[s]),
         .in_vd    (s_vd[s]),
         .in_idx   (s_idx[s]),
         .occupied (p_occ[s]),
         .s2_occ   (p_s2occ[s]),
         .s2_idx   (p_s2idx[s]),
         .wr_en    (p_we[s]),
         .wr_vd    (p_vd[s]),
         .wr_data  (p_wd[s])
      );
   end

   vxu_vrf #(.W(W), .MAXVL(MAXVL), .NREG(NREG), .NWR(NSLOT), .NRD(2*NSLOT)) u_vrf (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (p_we),
      .wreg     (p_vd),
      .widx     (p_s2idx),
      .wdata    (p_wd),
      .rreg     (rreg),
      .ridx     (ridx),
      .rdata    (rdata),
      .dbg_reg  (dbg_reg),
      .dbg_idx  (dbg_idx),
      .dbg_data (dbg_data)
   );

endmodule

// File: rtl/vxu_chain_chk.sv
module vxu_chain_chk #(
   parameter  int MAXVL = 64,
   localparam int IW    = (MAXVL > 1) ? $clog2(MAXVL) : 1,
   localparam int LW    = $clog2(MAXVL + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          iss_valid,
   input logic [2:0]    iss_op,
   input logic          iss_ready,
   input logic          busy,
   input logic [LW-1:0] len_q,
   input logic          b_issue,
   input logic [IW-1:0] b_idx,
   input logic          a_s2_occ,
   input logic [IW-1:0] a_s2_idx
);

   assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> iss_ready);

   assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= LW'(MAXVL));

   // The consumer never reads an element the producer has not yet reached.
   assert_chain_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (b_issue && a_s2_occ) |-> (a_s2_idx >= b_idx));

   assert_pair_stalls_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready && !iss_op[2] && busy) |=> !iss_ready);

endmodule

bind vxu_chain_unit vxu_chain_chk #(.MAXVL(MAXVL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_valid (iss_valid),
   .iss_op    (iss_op),
   .iss_ready (iss_ready),
   .busy      (busy),
   .len_q     (len_q),
   .b_issue   (s_iss[1]),
   .b_idx     (s_idx[1]),
   .a_s2_occ  (p_s2occ[0]),
   .a_s2_idx  (p_s2idx[0])
);

// File: tb/test_vxu_chain_unit.sv
`timescale 1ns/1ps
module test_vxu_chain_unit;
   import vxu_pkg::*;

   localparam int  W     = 64;
   localparam int  MAXVL = 64;
   localparam int  NREG  = 4;
   localparam int  RW    = 2;
   localparam int  IW    = 6;
   localparam time CLK_PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          iss_valid = 1'b0;
   logic [2:0]    iss_op = '0;
   logic [RW-1:0] iss_vd = '0, iss_vs1 = '0, iss_vs2 = '0;
   logic [W-1:0]  iss_scalar = '0;
   logic          iss_ready, busy;
   logic [RW-1:0] dbg_reg = '0;
   logic [IW-1:0] dbg_idx = '0;
   logic [W-1:0]  dbg_data;

   vxu_chain_unit #(.W(W), .MAXVL(MAXVL), .NREG(NREG)) i_vxu_chain_unit (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
      .iss_vd(iss_vd), .iss_vs1(iss_vs1), .iss_vs2(iss_vs2),
      .iss_scalar(iss_scalar), .iss_ready(iss_ready), .busy(busy),
      .dbg_reg(dbg_reg), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   logic [W-1:0]     mdl [NREG][MAXVL];
   int               m_len;
   logic [MAXVL-1:0] m_mask;

   task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic mdl_arith(input logic [2:0] op, input int vd, input int vs1,
                            input int vs2, input logic [W-1:0] sc);
      for (int e = 0; e < m_len; e++) begin
         logic [W-1:0] a, b;
         if (m_mask[e]) begin
            a = mdl[vs1][e];
            b = op[0] ? sc : mdl[vs2][e];
            mdl[vd][e] = op[1] ? a * b : a + b;
         end
      end
   endtask

   task automatic issue(input logic [2:0] op, input int vd, input int vs1,
                        input int vs2, input logic [W-1:0] sc, output bit rdy);
      @(negedge clk);
      iss_valid  = 1'b1;
      iss_op     = op;
      iss_vd     = RW'(vd);
      iss_vs1    = RW'(vs1);
      iss_vs2    = RW'(vs2);
      iss_scalar = sc;
      rdy        = iss_ready;
      @(posedge clk);
      #1 iss_valid = 1'b0;
   endtask

   task automatic set_len(input logic [W-1:0] v);
      bit r;
      issue(OP_SETLEN, 0, 0, 0, v, r);
      m_len = (v > MAXVL) ? MAXVL : int'(v);
   endtask

   task automatic set_mask(input logic [MAXVL-1:0] m);
      bit r;
      issue(OP_SETMASK, 0, 0, 0, W'(m), r);
      m_mask = m;
   endtask

   task automatic vop(input logic [2:0] op, input int vd, input int vs1, input int vs2,
                      input logic [W-1:0] sc, input string req);
      bit r;
      issue(op, vd, vs1, vs2, sc, r);
      chk({req, " ready at issue"}, W'(r), W'(1));
      mdl_arith(op, vd, vs1, vs2, sc);
   endtask

   // Counts rising edges until busy is seen low at a falling edge.
   task automatic wait_idle(output int cnt);
      cnt = 0;
      forever begin
         @(negedge clk);
         if (!busy) break;
         @(posedge clk);
         cnt++;
         if (cnt > 5000) break;
      end
   endtask

   task automatic cmp_all(input string req);
      int bad = 0;
      logic [W-1:0] fa = '0, fe = '0;
      for (int r = 0; r < NREG; r++)
         for (int e = 0; e < MAXVL; e++) begin
            dbg_reg = RW'(r);
            dbg_idx = IW'(e);
            #0.01;
            if (dbg_data !== mdl[r][e]) begin
               if (bad == 0) begin fa = dbg_data; fe = mdl[r][e]; end
               bad++;
            end
         end
      chk({req, " register contents"}, fa, fe);
   endtask

   task automatic t_reset();
      chk("R1 busy after reset", W'(busy), W'(0));
      chk("R1 ready after reset", W'(iss_ready), W'(1));
      cmp_all("R1");
   endtask

   // Builds v1[e] = e with masked scalar adds, one per index bit.
   task automatic t_iota();
      int c;
      set_len(MAXVL);
      for (int j = 0; j < IW; j++) begin
         logic [MAXVL-1:0] m;
         for (int e = 0; e < MAXVL; e++) m[e] = e[j];
         set_mask(m);
         vop(OP_ADDVS, 1, 1, 0, W'(1) << j, "R6");
         wait_idle(c);
      end
      set_mask('1);
      cmp_all("R6 index pattern");
   endtask

   task automatic t_add();
      int c;
      vop(OP_ADDVV, 2, 1, 1, '0, "R2");
      wait_idle(c);
      chk("R9 cycles for 64 elements", W'(c), W'(MAXVL + 2));
      cmp_all("R2");
      vop(OP_ADDVS, 3, 2, 0, 64'hFFFF_FFFF_FFFF_FFF0, "R3");
      wait_idle(c);
      cmp_all("R3 scalar add with wrap");
   endtask

   task automatic t_mul();
      int c;
      vop(OP_MULVV, 0, 1, 2, '0, "R4");
      wait_idle(c);
      cmp_all("R4 vector multiply");
      vop(OP_MULVS, 3, 3, 0, 64'h1234_5678_9ABC_DEF1, "R4");
      wait_idle(c);
      cmp_all("R4 scalar multiply low bits");
   endtask

   task automatic t_len();
      int c;
      set_len(10);
      vop(OP_ADDVS, 0, 0, 0, 64'd7, "R5");
      wait_idle(c);
      chk("R9 cycles for 10 elements", W'(c), W'(12));
      cmp_all("R5 elements above length kept");
   endtask

   task automatic t_mask();
      int c;
      set_len(MAXVL);
      set_mask({(MAXVL/2){2'b10}});
      vop(OP_ADDVV, 2, 2, 3, '0, "R6");
      wait_idle(c);
      cmp_all("R6 odd elements only");
      set_mask('1);
   endtask

   task automatic t_len0();
      int c;
      set_len(0);
      vop(OP_ADDVS, 2, 2, 0, 64'd1, "R7");
      wait_idle(c);
      chk("R7 busy for one cycle", W'(c), W'(1));
      cmp_all("R7 no writes");
   endtask

   task automatic t_clamp();
      int c;
      set_len(100);
      vop(OP_ADDVS, 3, 3, 0, 64'd3, "R8");
      wait_idle(c);
      chk("R8 clamped length cycles", W'(c), W'(MAXVL + 2));
      cmp_all("R8");
   endtask

   task automatic t_chain(input int n, input logic [MAXVL-1:0] m, input string tag);
      int c = 0, bad = 0;
      bit ra, rb;
      set_len(n);
      set_mask(m);
      issue(OP_MULVS, 0, 1, 0, 64'd7, ra);
      issue(OP_ADDVV, 2, 0, 2, '0, rb);
      chk({tag, " R10 producer ready"}, W'(ra), W'(1));
      chk({tag, " R10 consumer accepted"}, W'(rb), W'(1));
      mdl_arith(OP_MULVS, 0, 1, 0, 64'd7);
      mdl_arith(OP_ADDVV, 2, 0, 2, '0);
      forever begin
         @(negedge clk);
         if (!busy) break;
         if (iss_ready) bad++;
         @(posedge clk);
         c++;
         if (c > 5000) break;
      end
      chk({tag, " R11 ready low while pair runs"}, W'(bad), W'(0));
      chk({tag, " R11 ready after pair"}, W'(iss_ready), W'(1));
      chk({tag, " R10 pair cycles"}, W'(c), W'(n + 3));
      cmp_all({tag, " R10"});
      set_mask('1);
   endtask

   task automatic t_cfg_inflight();
      int c;
      bit r;
      set_len(8);
      issue(OP_ADDVS, 0, 0, 0, 64'd1, r);
      mdl_arith(OP_ADDVS, 0, 0, 0, 64'd1);
      set_len(3);
      wait_idle(c);
      cmp_all("R12 in-flight length kept");
      vop(OP_ADDVS, 0, 0, 0, 64'd2, "R12");
      wait_idle(c);
      chk("R12 new length applied", W'(c), W'(5));
      cmp_all("R12");
   endtask

   initial begin
      for (int r = 0; r < NREG; r++)
         for (int e = 0; e < MAXVL; e++) mdl[r][e] = '0;
      m_len  = MAXVL;
      m_mask = '1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_iota();
      t_add();
      t_mul();
      t_len();
      t_mask();
      t_len0();
      t_clamp();
      t_chain(16, '1, "full mask");
      t_chain(20, {(MAXVL/8){8'hF0}}, "daxpy masked");
      t_cfg_inflight();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule